// File: doc/BRIEF.md
# Predicated Vector Integer ALU Stage

This block is the integer arithmetic stage of a wide vector datapath that also serves every scalar instruction. There is no separate scalar unit: a scalar operation travels down the same lanes and only lane 0 carries a meaningful result. Each of the two source operands is presented as a full lane bus. A per-operand mode bit says whether the bus is a vector or whether only its lane 0 holds a scalar. A scalar source is replicated across every lane before the lanes compute, so mixed vector/scalar instructions need no separate splat step.

Write-back is predicated. When predication is on for a vector destination, the caller's mask picks which lanes update the destination. With predication off, every lane writes. A scalar destination writes lane 0 only. The stage has one cycle of latency: the lane results, the per-lane write-enables and a valid flag all come out of one register bank.

The block has no state machine. Its only state is the output register bank, which is loaded on a valid input and holds otherwise.

Top module: `vec_alu_stage`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `out_valid` is 0, `lane_we` is all zero and `result` is all zero.
- R2: Opcode encoding on `op`: 0 add, 1 subtract (a-b), 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 signed set-less-than (result 1 or 0). Lane i of the result is the operation applied to lane i of the effective operands.
- R3: When both operands are vectors, each lane computes independently from its own operand lanes. Lane i occupies bits [32*i+31:32*i] of each bus.
- R4: When `a_scalar` (or `b_scalar`) is 1, bits [31:0] of that operand bus are used in every lane and its other lanes are ignored.
- R5: When `dst_scalar` is 1, `lane_we` is 16'h0001 whatever `pred_en` and `mask` are, and result lanes 1 to 15 are zero.
- R6: When `pred_en` is 1 and `dst_scalar` is 0, `lane_we` equals `mask`. Bit i enables lane i.
- R7: When `pred_en` is 0 and `dst_scalar` is 0, `lane_we` is all ones whatever `mask` holds.
- R8: Outputs appear on the edge after `in_valid` is sampled high. `out_valid` follows `in_valid` with one cycle of delay. After a cycle with `in_valid` low, `lane_we` is zero and `result` keeps its previous value.
- R9: Shifts use only the low 5 bits of the b lane as the shift amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| op | input | 3 | Operation code |
| a_scalar | input | 1 | Operand a is a scalar in lane 0 |
| b_scalar | input | 1 | Operand b is a scalar in lane 0 |
| dst_scalar | input | 1 | Destination is scalar (lane 0 only) |
| pred_en | input | 1 | Apply mask to write-back |
| mask | input | 16 | Per-lane predicate |
| a_vec | input | 512 | Operand a lanes |
| b_vec | input | 512 | Operand b lanes |
| out_valid | output | 1 | Registered result valid |
| result | output | 512 | Registered lane results |
| lane_we | output | 16 | Registered per-lane write-enable |

## Verification
The clocked properties assume that `in_valid` is held low while reset is asserted, so that the first cycle after release carries no instruction captured during reset. They also assume that the control inputs carry no X when `in_valid` is high. The bench drives every input on the falling edge, keeps `in_valid` at 0 through reset, and then mixes seeded random opcodes, operand modes, masks and lane data with directed shift-amount, signed-compare and all-zero/all-one mask cases.

// File: rtl/vec_alu_pkg.sv
package vec_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6,
        OP_SLT = 3'd7
    } alu_op_t;

endpackage

// File: rtl/vec_alu_bcast.sv
module vec_alu_bcast #(
    parameter int LANES = 16,
    parameter int W     = 32
) (
    input  logic [LANES*W-1:0] vec_in,
    input  logic               scalar_mode,
    output logic [LANES*W-1:0] vec_out
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_base
            assign vec_out[W-1:0] = vec_in[W-1:0];
        end else begin : g_rep
            assign vec_out[i*W +: W] = scalar_mode ? vec_in[W-1:0] : vec_in[i*W +: W];
        end
    end

endmodule

// File: rtl/vec_alu_lane.sv
module vec_alu_lane
    import vec_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_t      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam int SHW = $clog2(W);

    logic [SHW-1:0] shamt;
    logic           lt;

    assign shamt = b[SHW-1:0];
    assign lt    = $signed(a) < $signed(b);

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = a << shamt;
            OP_SHR:  y = a >> shamt;
            OP_SLT:  y = {{(W-1){1'b0}}, lt};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/vec_alu_stage.sv
module vec_alu_stage
    import vec_alu_pkg::*;
#(
    parameter int LANES = 16,
    parameter int W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         op,
    input  logic               a_scalar,
    input  logic               b_scalar,
    input  logic               dst_scalar,
    input  logic               pred_en,
    input  logic [LANES-1:0]   mask,
    input  logic [LANES*W-1:0] a_vec,
    input  logic [LANES*W-1:0] b_vec,
    output logic               out_valid,
    output logic [LANES*W-1:0] result,
    output logic [LANES-1:0]   lane_we
);

    localparam int BUS_W = LANES * W;

    alu_op_t            op_q;
    logic [BUS_W-1:0]   a_eff;
    logic [BUS_W-1:0]   b_eff;
    logic [BUS_W-1:0]   lane_y;
    logic [BUS_W-1:0]   res_next;
    logic [LANES-1:0]   we_next;

    assign op_q = alu_op_t'(op);

    vec_alu_bcast #(.LANES(LANES), .W(W)) u_bcast_a (
        .vec_in      (a_vec),
        .scalar_mode (a_scalar),
        .vec_out     (a_eff)
    );

    vec_alu_bcast #(.LANES(LANES), .W(W)) u_bcast_b (
        .vec_in      (b_vec),
        .scalar_mode (b_scalar),
        .vec_out     (b_eff)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vec_alu_lane #(.W(W)) u_lane (
            .op (op_q),
            .a  (a_eff[i*W +: W]),
            .b  (b_eff[i*W +: W]),
            .y  (lane_y[i*W +: W])
        );
        if (i == 0) begin : g_l0
            assign res_next[W-1:0] = lane_y[W-1:0];
        end else begin : g_hi
            assign res_next[i*W +: W] = dst_scalar ? '0 : lane_y[i*W +: W];
        end
    end

    always_comb begin
        if (dst_scalar)   we_next = LANES'(1);
        else if (pred_en) we_next = mask;
        else              we_next = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            lane_we   <= '0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            lane_we   <= in_valid ? we_next : '0;
            if (in_valid) result <= res_next;
        end
    end

    // R8: valid pipelines with one cycle of delay
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && lane_we == '0 && $stable(result)));
    // R5: scalar destination enables lane 0 only
    p_scalar_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_scalar) |=> (lane_we == LANES'(1)));
    // R6: predicated vector write-back never exceeds the mask
    p_pred_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_en && !dst_scalar) |=> ((lane_we & ~$past(mask)) == '0));
    // R7: unpredicated vector write-back enables every lane
    p_nopred_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pred_en && !dst_scalar) |=> ($countones(lane_we) == LANES));

endmodule

// File: tb/vec_alu_stage_bench.sv
module vec_alu_stage_bench;

    localparam int LANES = 16;
    localparam int W     = 32;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_W = LANES * W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [2:0]       op = '0;
    logic             a_scalar = 1'b0, b_scalar = 1'b0, dst_scalar = 1'b0, pred_en = 1'b0;
    logic [LANES-1:0] mask = '0;
    logic [BUS_W-1:0] a_vec = '0, b_vec = '0;
    logic             out_valid;
    logic [BUS_W-1:0] result;
    logic [LANES-1:0] lane_we;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_alu_stage #(.LANES(LANES), .W(W)) u_vec_alu_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .a_scalar(a_scalar), .b_scalar(b_scalar), .dst_scalar(dst_scalar),
        .pred_en(pred_en), .mask(mask), .a_vec(a_vec), .b_vec(b_vec),
        .out_valid(out_valid), .result(result), .lane_we(lane_we)
    );

    function automatic logic [W-1:0] ref_op(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
        case (o)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a << b[4:0];
            3'd6: return a >> b[4:0];
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] ref_result();
        logic [BUS_W-1:0] r = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [W-1:0] la = a_scalar ? a_vec[W-1:0] : a_vec[i*W +: W];
            logic [W-1:0] lb = b_scalar ? b_vec[W-1:0] : b_vec[i*W +: W];
            if (!dst_scalar || i == 0) r[i*W +: W] = ref_op(op, la, lb);
        end
        return r;
    endfunction

    function automatic logic [LANES-1:0] ref_we();
        if (dst_scalar) return LANES'(1);
        if (pred_en)    return mask;
        return '1;
    endfunction

    task automatic chk_bus(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s result act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_we(input string tag, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s lane_we act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s out_valid act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic rand_bus(output logic [BUS_W-1:0] v);
        for (int i = 0; i < LANES; i++) v[i*W +: W] = $urandom;
    endtask

    // Inputs set by caller at a falling edge; checked one falling edge later.
    task automatic run_op(input string tag);
        logic [BUS_W-1:0] er;
        logic [LANES-1:0] ew;
        er = ref_result();
        ew = ref_we();
        in_valid = 1'b1;
        @(negedge clk);
        chk_bit(tag, out_valid, 1'b1);
        chk_bus(tag, result, er);
        chk_we(tag, lane_we, ew);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_bit("R1", out_valid, 1'b0);
        chk_we("R1", lane_we, '0);
        chk_bus("R1", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1 post", out_valid, 1'b0);
        chk_bus("R1 post", result, '0);

        // R2 R3: every opcode, vector/vector, no predication (R7)
        for (int o = 0; o < 8; o++) begin
            op = 3'(o);
            a_scalar = 0; b_scalar = 0; dst_scalar = 0; pred_en = 0;
            mask = 16'h0000;
            rand_bus(a_vec); rand_bus(b_vec);
            run_op("R2 R3 R7");
        end

        // R9: shift amounts use low 5 bits only
        a_scalar = 0; b_scalar = 0; dst_scalar = 0; pred_en = 0;
        for (int i = 0; i < LANES; i++) begin
            a_vec[i*W +: W] = 32'h8000_0001;
            b_vec[i*W +: W] = 32'hFFFF_FFE0 | 32'(i * 2);
        end
        op = 3'd5; run_op("R9 shl");
        op = 3'd6; run_op("R9 shr");

        // R2: signed compare corners
        op = 3'd7;
        a_vec = '0; b_vec = '0;
        a_vec[W-1:0] = 32'h8000_0000; b_vec[W-1:0] = 32'h7FFF_FFFF;
        a_vec[W +: W] = 32'h7FFF_FFFF; b_vec[W +: W] = 32'h8000_0000;
        a_vec[2*W +: W] = 32'hFFFF_FFFF; b_vec[2*W +: W] = 32'h0;
        run_op("R2 slt");

        // R4: scalar broadcast on a, on b, and on both
        op = 3'd0;
        rand_bus(a_vec); rand_bus(b_vec);
        a_scalar = 1; b_scalar = 0; run_op("R4 a");
        a_scalar = 0; b_scalar = 1; op = 3'd1; run_op("R4 b");
        a_scalar = 1; b_scalar = 1; op = 3'd4; run_op("R4 both");
        a_scalar = 0; b_scalar = 0;

        // R5: scalar destination ignores mask and predication
        dst_scalar = 1; pred_en = 1; mask = 16'h0000; op = 3'd3;
        run_op("R5 mask0");
        pred_en = 0; mask = 16'hFFFE; run_op("R5 nopred");
        dst_scalar = 0;

        // R6 R7: mask corners
        pred_en = 1; mask = 16'h0000; run_op("R6 none");
        mask = 16'hFFFF; run_op("R6 all");
        mask = 16'hA5C3; run_op("R6 pattern");
        pred_en = 0; mask = 16'h0000; run_op("R7 ignore mask");

        // R8: idle cycles hold result and clear write-enables
        begin
            logic [BUS_W-1:0] held;
            held = result;
            repeat (2) @(negedge clk);
            chk_bit("R8 idle", out_valid, 1'b0);
            chk_we("R8 idle", lane_we, '0);
            chk_bus("R8 hold", result, held);
        end

        // Random mix
        for (int n = 0; n < 400; n++) begin
            op = 3'($urandom_range(0, 7));
            a_scalar = 1'($urandom); b_scalar = 1'($urandom);
            dst_scalar = ($urandom_range(0, 3) == 0);
            pred_en = 1'($urandom);
            mask = 16'($urandom);
            rand_bus(a_vec); rand_bus(b_vec);
            if ($urandom_range(0, 3) == 0) b_vec[W-1:0] = 32'($urandom_range(0, 40));
            run_op("R2 R4 R5 R6 R7 rand");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule